// File: doc/BRIEF.md
# UART Receive Buffer with Per-Character Error Flags

This block sits between a UART receive state machine and the host register interface. Each received character is stored together with its own break, framing and parity flags. The flags therefore always describe the character they arrived with, however many characters wait in the buffer. The host sees two views. The line-status view shows the flags of the oldest stored character, a data-ready bit, an overrun bit and an aggregate "some stored character is bad" bit. The holding-register view shows the oldest character's data.

Reading line status only observes the buffer. Reading the holding register removes the oldest entry, so the next entry's data and flags are then shown. A character that arrives while the buffer is full, with no removal in the same cycle, is an overrun. The character is dropped, an overrun bit and a line-status interrupt code are raised, and a lock stops all further storing. The host recovers in two steps: it clears the buffer, then reads the resume strobe. The order of these steps matters.

Top module: `uart_rx_errbuf`

## Requirements
- R1: After reset, `lsr_q` is 0, `rhr_q` is 0, `iir_type` is 0 and `rx_locked` is 0.
- R2: Accepted characters leave in arrival order. `rhr_q` shows the oldest stored data byte, or 0 when empty. `lsr_q[0]` is 1 exactly when at least one entry is stored.
- R3: `lsr_q[4]`, `lsr_q[3]` and `lsr_q[2]` show the break, framing and parity flags of the oldest stored entry, and read 0 when the buffer is empty. `lsr_q[6:5]` are always 0.
- R4: A line-status read strobe (`lsr_rd`) never removes an entry. The shown data and flags stay unchanged by it.
- R5: A holding-register read strobe (`rhr_rd`) removes the oldest entry, and its effect shows from the next cycle. On an empty buffer it has no effect.
- R6: `lsr_q[7]` is 1 while any stored entry has at least one of its three flags set. It is 0 once none remains.
- R7: A write strobe while the buffer holds DEPTH entries, with no removal in that cycle and no lock in place, is an overrun. The character is dropped. `lsr_q[1]` becomes 1 and `iir_type` reads 5'h3 from the next cycle. `iir_type` is 5'h0 whenever `lsr_q[1]` is 0.
- R8: A line-status read clears `lsr_q[1]` in the following cycle, unless a new overrun happens in the same cycle.
- R9: An overrun sets `rx_locked` from the next cycle. While locked, write strobes store nothing. A buffer clear (`fifo_clr`) empties the buffer and zeroes `lsr_q[7:2]` and `lsr_q[0]`, but leaves the lock in place.
- R10: `resume_rd` releases the lock only if a buffer clear happened after the overrun, in an earlier cycle. A resume read before that has no effect.
- R11: A write and a holding-register read in the same cycle on a full buffer are both honoured. The buffer stays full, the new character is stored and no overrun is flagged.
- R12: A buffer clear takes priority over a write or read in the same cycle. The buffer is empty afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Receive state machine offers a character this cycle |
| wr_data | input | 8 | Received data byte |
| wr_brk | input | 1 | Break flag of the offered character |
| wr_fe | input | 1 | Framing error flag of the offered character |
| wr_pe | input | 1 | Parity error flag of the offered character |
| fifo_clr | input | 1 | Buffer clear strobe |
| lsr_rd | input | 1 | Line-status read strobe |
| rhr_rd | input | 1 | Holding-register read strobe (removes the oldest entry) |
| resume_rd | input | 1 | Resume read strobe (releases the lock after a clear) |
| rhr_q | output | 8 | Oldest stored data byte |
| lsr_q | output | 8 | Line status: [7] any error stored, [4] break, [3] framing, [2] parity, [1] overrun, [0] data ready |
| iir_type | output | 5 | Interrupt type code: 5'h3 on pending overrun, else 5'h0 |
| rx_locked | output | 1 | Reception disabled after an overrun |

## Verification
Two pairs of functions can fall in the same cycle. The first is a write and a removal on a full buffer, which must not count as an overrun. The second is a line-status read in the cycle that an overrun arises, where the new overrun must win. The bench fills the buffer to exactly DEPTH and then strikes both strobes together. A random phase also keeps the buffer near full while read strobes fire often, so both collisions happen many times. A queue model in the bench, run cycle by cycle, judges each case. It gives the removal first and then decides overrun by the occupancy left.

// File: rtl/rxbuf_pkg.sv
package rxbuf_pkg;

  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              fe;
    logic              pe;
    logic [DATA_W-1:0] data;
  } rx_entry_t;

  localparam logic [4:0] IT_NONE        = 5'h0;
  localparam logic [4:0] IT_LINE_STATUS = 5'h3;

  // true when the entry carries any error flag
  function automatic logic f_flagged(rx_entry_t e);
    return e.brk | e.fe | e.pe;
  endfunction

  // occupancy-style counter update: one up, one down, both, or neither
  function automatic int unsigned f_adjust(int unsigned cur, logic up, logic down);
    return cur + int'(up) - int'(down);
  endfunction

endpackage

// File: rtl/rxbuf_store.sv
module rxbuf_store
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          push,
  input  logic          pop,
  input  rx_entry_t     din,
  output rx_entry_t     head,
  output logic [CW-1:0] occ,
  output logic          empty,
  output logic          full
);

  rx_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ_q;

  function automatic logic [AW-1:0] f_wrap(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else if (clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ_q  <= '0;
    end else begin
      if (push) wr_ptr <= f_wrap(wr_ptr);
      if (pop)  rd_ptr <= f_wrap(rd_ptr);
      occ_q <= CW'(f_adjust(int'(occ_q), push, pop));
    end
  end

  assign occ   = occ_q;
  assign empty = (occ_q == '0);
  assign full  = (occ_q == CW'(DEPTH));
  assign head  = empty ? '0 : mem[rd_ptr];

endmodule

// File: rtl/rxbuf_errcnt.sv
module rxbuf_errcnt
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          any_err
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (clr) cnt_q <= '0;
    else          cnt_q <= CW'(f_adjust(int'(cnt_q), inc, dec));
  end

  assign cnt     = cnt_q;
  assign any_err = (cnt_q != '0);

endmodule

// File: rtl/rxbuf_lock.sv
module rxbuf_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic wr_valid,
  input  logic full,
  input  logic pop_ok,
  input  logic lsr_rd,
  input  logic resume_rd,
  output logic push_ok,
  output logic ovr_evt,
  output logic ovr_flag,
  output logic locked
);

  logic ovr_q, lock_q, clr_seen_q;
  logic offer;

  assign offer   = wr_valid && !lock_q && !clr;
  assign ovr_evt = offer && full && !pop_ok;
  assign push_ok = offer && (!full || pop_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q      <= 1'b0;
      lock_q     <= 1'b0;
      clr_seen_q <= 1'b0;
    end else begin
      if (ovr_evt)     ovr_q <= 1'b1;
      else if (lsr_rd) ovr_q <= 1'b0;

      if (ovr_evt) begin
        lock_q     <= 1'b1;
        clr_seen_q <= 1'b0;
      end else if (resume_rd && clr_seen_q) begin
        lock_q     <= 1'b0;
        clr_seen_q <= 1'b0;
      end else if (clr && lock_q) begin
        clr_seen_q <= 1'b1;
      end
    end
  end

  assign ovr_flag = ovr_q;
  assign locked   = lock_q;

endmodule

// File: rtl/uart_rx_errbuf.sv
module uart_rx_errbuf
  import rxbuf_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  input  logic       wr_brk,
  input  logic       wr_fe,
  input  logic       wr_pe,
  input  logic       fifo_clr,
  input  logic       lsr_rd,
  input  logic       rhr_rd,
  input  logic       resume_rd,
  output logic [7:0] rhr_q,
  output logic [7:0] lsr_q,
  output logic [4:0] iir_type,
  output logic       rx_locked
);

  rx_entry_t     din, head;
  logic [CW-1:0] occ, err_cnt;
  logic          empty, full, err_any;
  logic          pop_ok, push_ok, ovr_evt, ovr_flag;

  assign din    = '{brk: wr_brk, fe: wr_fe, pe: wr_pe, data: wr_data};
  assign pop_ok = rhr_rd && !empty && !fifo_clr;

  rxbuf_lock u_lock (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (fifo_clr),
    .wr_valid  (wr_valid),
    .full      (full),
    .pop_ok    (pop_ok),
    .lsr_rd    (lsr_rd),
    .resume_rd (resume_rd),
    .push_ok   (push_ok),
    .ovr_evt   (ovr_evt),
    .ovr_flag  (ovr_flag),
    .locked    (rx_locked)
  );

  rxbuf_store #(.DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (fifo_clr),
    .push  (push_ok),
    .pop   (pop_ok),
    .din   (din),
    .head  (head),
    .occ   (occ),
    .empty (empty),
    .full  (full)
  );

  rxbuf_errcnt #(.DEPTH(DEPTH)) u_err (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (fifo_clr),
    .inc     (push_ok && f_flagged(din)),
    .dec     (pop_ok && f_flagged(head)),
    .cnt     (err_cnt),
    .any_err (err_any)
  );

  assign rhr_q    = head.data;
  assign lsr_q    = {err_any, 2'b00, head.brk, head.fe, head.pe, ovr_flag, !empty};
  assign iir_type = ovr_flag ? IT_LINE_STATUS : IT_NONE;

endmodule

// File: rtl/rxbuf_chk.sv
module rxbuf_chk #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_valid,
  input logic          rhr_rd,
  input logic          lsr_rd,
  input logic          fifo_clr,
  input logic [7:0]    rhr_q,
  input logic [7:0]    lsr_q,
  input logic [4:0]    iir_type,
  input logic          rx_locked,
  input logic [CW-1:0] occ,
  input logic [CW-1:0] err_cnt,
  input logic          full,
  input logic          pop_ok,
  input logic          ovr_evt
);

  AST_OVR_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_evt |=> rx_locked && lsr_q[1] && iir_type == 5'h3); // R7

  AST_LSR_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !rhr_rd && !fifo_clr && occ != '0) |=>
      (rhr_q == $past(rhr_q) && lsr_q[4:2] == $past(lsr_q[4:2]))); // R4

  AST_LOCKED_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_locked && !fifo_clr) |=> occ <= $past(occ)); // R9

  AST_FULL_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_valid && pop_ok && !rx_locked && !fifo_clr) |-> !ovr_evt); // R11

  AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (occ == '0 && lsr_q[7] == 1'b0 && lsr_q[0] == 1'b0)); // R12

  AST_ERR_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= occ); // R6

  AST_LSR_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
    (lsr_rd && !ovr_evt) |=> !lsr_q[1]); // R8

  AST_EMPTY_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (lsr_q[7:2] == 6'b0)); // R3

endmodule

bind uart_rx_errbuf rxbuf_chk #(.DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .rhr_rd    (rhr_rd),
  .lsr_rd    (lsr_rd),
  .fifo_clr  (fifo_clr),
  .rhr_q     (rhr_q),
  .lsr_q     (lsr_q),
  .iir_type  (iir_type),
  .rx_locked (rx_locked),
  .occ       (occ),
  .err_cnt   (err_cnt),
  .full      (full),
  .pop_ok    (pop_ok),
  .ovr_evt   (ovr_evt)
);

// File: tb/uart_rx_errbuf_tb.sv
module uart_rx_errbuf_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 64;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_valid, wr_brk, wr_fe, wr_pe;
  logic [7:0] wr_data;
  logic       fifo_clr, lsr_rd, rhr_rd, resume_rd;
  logic [7:0] rhr_q, lsr_q;
  logic [4:0] iir_type;
  logic       rx_locked;

  int n_chk  = 0;
  int n_fail = 0;

  // bench model: entry = {brk, fe, pe, data}
  logic [10:0] q[$];
  logic        m_ovr, m_lock, m_clr_seen;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_rx_errbuf #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_brk(wr_brk), .wr_fe(wr_fe), .wr_pe(wr_pe), .fifo_clr(fifo_clr),
    .lsr_rd(lsr_rd), .rhr_rd(rhr_rd), .resume_rd(resume_rd),
    .rhr_q(rhr_q), .lsr_q(lsr_q), .iir_type(iir_type), .rx_locked(rx_locked)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic m_any_err();
    foreach (q[i]) if (q[i][10:8] != 3'b000) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] m_lsr();
    logic [2:0] fl = (q.size() > 0) ? q[0][10:8] : 3'b000;
    return {m_any_err(), 2'b00, fl, m_ovr, q.size() > 0};
  endfunction

  task automatic compare_all();
    chk("R2 data", rhr_q, (q.size() > 0) ? q[0][7:0] : 0);
    chk("R2 ready", lsr_q[0], q.size() > 0);
    chk("R3 flags", {lsr_q[6:2]}, {2'b00, m_lsr()[4:2]});
    chk("R6 any", lsr_q[7], m_any_err());
    chk("R8 ovr", lsr_q[1], m_ovr);
    chk("R7 iir", iir_type, m_ovr ? 5'h3 : 5'h0);
    chk("R9 lock", rx_locked, m_lock);
  endtask

  // one cycle: drive at negedge, update model, compare at next negedge
  task automatic step(input logic w, input logic [10:0] e, input logic lr,
                      input logic rr, input logic cl, input logic rs);
    logic pop_ok, push_ok, ovr_ev, rel;
    wr_valid = w; {wr_brk, wr_fe, wr_pe, wr_data} = e;
    lsr_rd = lr; rhr_rd = rr; fifo_clr = cl; resume_rd = rs;
    pop_ok  = rr && q.size() > 0 && !cl;
    push_ok = w && !m_lock && !cl;
    ovr_ev  = push_ok && q.size() == DEPTH && !pop_ok;
    rel     = rs && m_clr_seen;
    if (cl) q.delete();
    else begin
      if (pop_ok) void'(q.pop_front());
      if (push_ok && !ovr_ev) q.push_back(e);
    end
    m_ovr = ovr_ev ? 1'b1 : (lr ? 1'b0 : m_ovr);
    if (ovr_ev) begin m_lock = 1'b1; m_clr_seen = 1'b0; end
    else if (rel) begin m_lock = 1'b0; m_clr_seen = 1'b0; end
    else if (cl && m_lock) m_clr_seen = 1'b1;
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  task automatic idle();
    step(0, 11'h0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    {wr_valid, wr_brk, wr_fe, wr_pe, wr_data} = '0;
    {fifo_clr, lsr_rd, rhr_rd, resume_rd} = '0;
    m_ovr = 0; m_lock = 0; m_clr_seen = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 lsr", lsr_q, 0); chk("R1 rhr", rhr_q, 0);
    chk("R1 iir", iir_type, 0); chk("R1 lock", rx_locked, 0);
    rst_n = 1'b1;
    idle();

    // R2/R3/R4: three characters with distinct flags, status reads don't pop
    step(1, {3'b100, 8'hA1}, 0, 0, 0, 0);
    step(1, {3'b010, 8'hB2}, 0, 0, 0, 0);
    step(1, {3'b001, 8'hC3}, 0, 0, 0, 0);
    step(0, 11'h0, 1, 0, 0, 0);
    step(0, 11'h0, 1, 0, 0, 0);
    chk("R4 head kept", rhr_q, 8'hA1);
    chk("R4 brk kept", lsr_q[4], 1);
    step(0, 11'h0, 0, 1, 0, 0);
    chk("R5 popped", rhr_q, 8'hB2);
    chk("R3 fe head", lsr_q[4:2], 3'b010);
    step(0, 11'h0, 0, 1, 0, 0);
    step(0, 11'h0, 0, 1, 0, 0);
    chk("R6 cleared", lsr_q[7], 0);
    step(0, 11'h0, 0, 1, 0, 0);
    chk("R5 empty pop ignored", lsr_q[0], 0);

    // R11: fill, then push+pop on full
    for (int i = 0; i < DEPTH; i++) step(1, {3'b000, 8'(i)}, 0, 0, 0, 0);
    step(1, {3'b011, 8'hEE}, 0, 1, 0, 0);
    chk("R11 no ovr", lsr_q[1], 0);
    chk("R11 no lock", rx_locked, 0);
    chk("R11 head advanced", rhr_q, 8'h01);
    chk("R11 err stored", lsr_q[7], 1);

    // R7: overrun, simultaneous status read loses to it
    step(1, {3'b000, 8'h55}, 1, 0, 0, 0);
    chk("R7 ovr set", lsr_q[1], 1);
    chk("R7 iir", iir_type, 5'h3);
    // R9: locked push ignored
    step(0, 11'h0, 0, 1, 0, 0);
    step(1, {3'b000, 8'h66}, 0, 0, 0, 0);
    chk("R9 locked ignore", lsr_q[0], 1);
    // R10: resume before clear has no effect
    step(0, 11'h0, 0, 0, 0, 1);
    chk("R10 early resume", rx_locked, 1);
    // R9: clear keeps lock
    step(0, 11'h0, 0, 0, 1, 0);
    chk("R9 clr empties", lsr_q[0], 0);
    chk("R9 lock kept", rx_locked, 1);
    step(1, {3'b000, 8'h77}, 0, 0, 0, 0);
    step(0, 11'h0, 0, 0, 0, 1);
    chk("R10 released", rx_locked, 0);
    step(0, 11'h0, 1, 0, 0, 0);
    chk("R8 ovr cleared", lsr_q[1], 0);

    // R12: clear beats a same-cycle write
    step(1, {3'b100, 8'h11}, 0, 0, 0, 0);
    step(1, {3'b100, 8'h22}, 0, 1, 1, 0);
    chk("R12 clr wins", lsr_q[0], 0);
    chk("R12 no err", lsr_q[7], 0);

    // random phase, biased toward a near-full buffer
    for (int n = 0; n < 4000; n++) begin
      int wp = (n % 1000 < 500) ? 70 : 45;
      logic w  = ($urandom % 100) < wp;
      logic rr = ($urandom % 100) < 45;
      logic lr = ($urandom % 100) < 15;
      logic cl = ($urandom % 100) < 2;
      logic rs = ($urandom % 100) < 4;
      logic [2:0] fl = (($urandom % 4) == 0) ? 3'($urandom) : 3'b000;
      step(w, {fl, 8'($urandom)}, lr, rr, cl, rs);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule